// File: doc/BRIEF.md
# Programmable High/Low Clock Divider

This block divides one input clock by an integer ratio set from two 4-bit fields. One field gives how many input cycles the output spends low, the other how many it spends high. Each count is the field value plus one, so the ratio is the sum of both fields plus two and covers 2 to 32. A bypass setting sends the input clock straight to the output and holds the counter idle.

A correction stage is on unless its disable input is set. It gives a 50% output for every ratio. Odd ratios are handled by ORing the rising-edge output with a copy taken on the falling edge, which adds half an input period to the high time. A start offset, counted in whole input cycles, delays the first output rise after reset or after a restart pulse. New ratio, bypass and correction settings are taken over only where an output period ends, so a change never cuts a pulse short.

Top module: `clkdiv_hl_top`

## Requirements
- R1: While reset is held, and for the first cycle after it, with bypass clear, `clk_out` is 0.
- R2: With correction disabled (`cfg_dcc_off`=1), each output period is low for `cfg_low`+1 input cycles and then high for `cfg_high`+1 input cycles.
- R3: The output period is `cfg_low`+`cfg_high`+2 input cycles, from 2 (both fields 0) to 32 (both fields 15).
- R4: With `cfg_bypass`=1 in effect, `clk_out` equals `clk` (high in the high phase, low in the low phase of every input cycle).
- R5: Correction is on when `cfg_dcc_off`=0, and then an even ratio D gives a high time of exactly D/2 input cycles.
- R6: With correction on and an odd ratio D, the high time is D/2 input periods (a whole number plus one half period) and the period stays D cycles.
- R7: With correction off and `cfg_low` not equal to `cfg_high`, an even ratio gives a duty cycle other than 50%.
- R8: When `restart` is sampled 1 at edge E0, the next rising edge of `clk_out` comes at the rising input edge numbered 1+P+L after E0, where P is `cfg_phase` at E0 and L is the low count in effect.
- R9: A change of `cfg_low`, `cfg_high`, `cfg_bypass` or `cfg_dcc_off` takes effect only after the output period in progress has ended; the current high phase keeps its full length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_low | input | 4 | Low count minus one |
| cfg_high | input | 4 | High count minus one |
| cfg_bypass | input | 1 | 1 = pass the input clock through (divide by 1) |
| cfg_dcc_off | input | 1 | 1 = duty-cycle correction disabled |
| cfg_phase | input | PHASE_W | Start offset in input cycles, taken at reset or restart |
| restart | input | 1 | Synchronous pulse: reload counters and wait the offset again |
| clk_out | output | 1 | Divided clock |

## Verification
The assertions assume that reset is held for at least one full input cycle, so the falling-edge stage is also cleared, and that `restart` and the configuration inputs change only between edges. The stimulus holds reset for several cycles, and it moves the configuration and restart inputs on the falling input edge. The counter and falling-edge checks therefore never see a value that is only half loaded. The checks on the output shape wait for more than one full maximum period after each change. This lets the deferred update of R9 settle before measuring.

// File: rtl/clkdiv_pkg.sv
// Shared types and helpers for the high/low clock divider.
// Assumes: both count fields have the same width.
package clkdiv_pkg;
    localparam int FIELD_W = 4;
    localparam int CNT_W   = FIELD_W + 2;

    typedef struct packed {
        logic [FIELD_W-1:0] low;
        logic [FIELD_W-1:0] high;
        logic               bypass;
        logic               dcc_on;
    } cd_cfg_t;

    // Output period in input cycles: (low+1)+(high+1).
    function automatic logic [CNT_W-1:0] span_of(cd_cfg_t c);
        return {2'b00, c.low} + {2'b00, c.high} + CNT_W'(2);
    endfunction

    // Count index at which the output goes high.
    function automatic logic [CNT_W-1:0] thr_of(cd_cfg_t c);
        logic [CNT_W-1:0] d;
        d = span_of(c);
        if (c.dcc_on)
            return (d + CNT_W'(1)) >> 1;
        return {2'b00, c.low} + CNT_W'(1);
    endfunction
endpackage

// File: rtl/cd_cfg_hold.sv
// Holds the configuration in effect and offers the one that will be in
// effect after the coming edge. Assumes load is high only at a period
// boundary, during the start wait, in bypass or on restart.
module cd_cfg_hold
    import clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  cd_cfg_t          cfg_in,
    output cd_cfg_t          act,
    output cd_cfg_t          eff,
    output logic [CNT_W-1:0] act_span,
    output logic [CNT_W-1:0] act_thr,
    output logic [CNT_W-1:0] eff_thr
);
    // Pick the settings that the next cycle will use.
    always_comb begin
        eff      = load ? cfg_in : act;
        act_span = span_of(act);
        act_thr  = thr_of(act);
        eff_thr  = thr_of(eff);
    end

    // Register the settings in effect; reset takes the inputs directly.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act <= cfg_in;
        else if (load)
            act <= cfg_in;
    end
endmodule

// File: rtl/cd_phase_core.sv
// Start-offset wait and the period counter that drives the rising-edge
// output phase. Assumes eff_* come from cd_cfg_hold for the same edge.
module cd_phase_core
    import clkdiv_pkg::*;
#(
    parameter int PHASE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic [PHASE_W-1:0] phase_in,
    input  logic [CNT_W-1:0]   act_span,
    input  logic [CNT_W-1:0]   act_thr,
    input  logic               act_bypass,
    input  logic [CNT_W-1:0]   eff_thr,
    input  logic               eff_bypass,
    output logic               load,
    output logic               run,
    output logic [CNT_W-1:0]   cnt,
    output logic               pos_q
);
    logic [PHASE_W-1:0] wcnt;
    logic [PHASE_W-1:0] phase_r;
    logic               wrap;
    logic [CNT_W-1:0]   cnt_n;

    // Decide where a period ends and when new settings may enter.
    always_comb begin
        wrap  = run && (cnt == act_span - CNT_W'(1));
        load  = restart || !run || act_bypass || wrap;
        cnt_n = (act_bypass || wrap) ? '0 : cnt + CNT_W'(1);
    end

    // Offset wait, then count the period and register the output level.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            run     <= 1'b0;
            wcnt    <= '0;
            cnt     <= '0;
            pos_q   <= 1'b0;
            phase_r <= phase_in;
        end else if (!run) begin
            cnt   <= '0;
            pos_q <= 1'b0;
            if (wcnt == phase_r)
                run <= 1'b1;
            else
                wcnt <= wcnt + PHASE_W'(1);
        end else begin
            cnt   <= cnt_n;
            pos_q <= !eff_bypass && (cnt_n >= eff_thr);
        end
    end

    // R3: the counter stays inside the period.
    a_r3_cnt_in_span: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < act_span));
    // R8: nothing is driven while the offset is pending.
    a_r8_wait_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !pos_q);
    // R8: the wait counter never passes the stored offset.
    a_r8_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (wcnt <= phase_r));
    // R4: bypass keeps the counter idle.
    a_r4_bypass_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (run && act_bypass && !restart) |=> (cnt == '0 && !pos_q));
    // R2: the output rises only at the threshold count.
    a_r2_rise_at_thr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pos_q) |-> (cnt == act_thr));
endmodule

// File: rtl/cd_half_shift.sv
// Falling-edge copy of the rising-edge output phase, used to stretch the
// high time by half an input period for odd ratios with correction on.
// Assumes reset spans at least one falling edge.
module cd_half_shift (
    input  logic clk,
    input  logic rst_n,
    input  logic pos_q,
    input  logic enable,
    output logic neg_q
);
    // Sample the rising-edge phase half a cycle later.
    always_ff @(negedge clk) begin
        if (!rst_n)
            neg_q <= 1'b0;
        else
            neg_q <= pos_q & enable;
    end

    // R6: the half-cycle stretch exists only for odd corrected ratios.
    a_r6_neg_only_odd: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !neg_q);
    // R6: the stretch always starts inside a high phase.
    a_r6_neg_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(neg_q) |-> pos_q);
endmodule

// File: rtl/clkdiv_hl_top.sv
// High/low programmable clock divider with optional 50% correction,
// bypass and start offset. Assumes the configuration inputs are
// synchronous to clk; clk_out is a combinational mux onto clk in bypass.
module clkdiv_hl_top
    import clkdiv_pkg::*;
#(
    parameter int PHASE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] cfg_low,
    input  logic [FIELD_W-1:0] cfg_high,
    input  logic               cfg_bypass,
    input  logic               cfg_dcc_off,
    input  logic [PHASE_W-1:0] cfg_phase,
    input  logic               restart,
    output logic               clk_out
);
    cd_cfg_t          cfg_in, act, eff;
    logic [CNT_W-1:0] act_span, act_thr, eff_thr, cnt;
    logic             load, run, pos_q, neg_q, odd_fix;

    // Pack the configuration pins; correction is on unless disabled.
    always_comb begin
        cfg_in.low    = cfg_low;
        cfg_in.high   = cfg_high;
        cfg_in.bypass = cfg_bypass;
        cfg_in.dcc_on = !cfg_dcc_off;
    end

    cd_cfg_hold u_cfg (
        .clk(clk), .rst_n(rst_n), .load(load), .cfg_in(cfg_in),
        .act(act), .eff(eff), .act_span(act_span),
        .act_thr(act_thr), .eff_thr(eff_thr)
    );

    cd_phase_core #(.PHASE_W(PHASE_W)) u_core (
        .clk(clk), .rst_n(rst_n), .restart(restart), .phase_in(cfg_phase),
        .act_span(act_span), .act_thr(act_thr), .act_bypass(act.bypass),
        .eff_thr(eff_thr), .eff_bypass(eff.bypass),
        .load(load), .run(run), .cnt(cnt), .pos_q(pos_q)
    );

    // Half-cycle stretch applies to odd corrected ratios only.
    always_comb odd_fix = act.dcc_on && act_span[0] && !act.bypass;

    cd_half_shift u_half (
        .clk(clk), .rst_n(rst_n), .pos_q(pos_q), .enable(odd_fix),
        .neg_q(neg_q)
    );

    // Output select: raw input in bypass, else both phases merged.
    always_comb clk_out = act.bypass ? clk : (pos_q | neg_q);

    // R9: settings in effect stay put inside a running period.
    a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !act.bypass && !restart && cnt != act_span - CNT_W'(1))
        |=> $stable(act));
endmodule

// File: tb/tb_clkdiv_hl_top.sv
module tb_clkdiv_hl_top;
    localparam int PERIOD  = 10;
    localparam int QTR     = PERIOD / 4;
    localparam int PHASE_W = 4;

    logic               clk = 1'b0;
    logic               rst_n;
    logic [3:0]         cfg_low, cfg_high;
    logic               cfg_bypass, cfg_dcc_off;
    logic [PHASE_W-1:0] cfg_phase;
    logic               restart;
    logic               clk_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    clkdiv_hl_top #(.PHASE_W(PHASE_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_low(cfg_low), .cfg_high(cfg_high),
        .cfg_bypass(cfg_bypass), .cfg_dcc_off(cfg_dcc_off),
        .cfg_phase(cfg_phase), .restart(restart), .clk_out(clk_out)
    );

    always #(PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic set_cfg(input int lo, input int hi, input bit byp, input bit off);
        @(negedge clk);
        cfg_low     = 4'(lo);
        cfg_high    = 4'(hi);
        cfg_bypass  = byp;
        cfg_dcc_off = off;
    endtask

    // Samples two points per input cycle; returns period and high time in half cycles.
    task automatic measure(output int per, output int hi);
        bit s [0:255];
        int first;
        first = -1;
        per = 0;
        hi = 0;
        for (int k = 0; k < 128; k++) begin
            @(posedge clk); #(QTR); s[2*k] = clk_out;
            @(negedge clk); #(QTR); s[2*k+1] = clk_out;
        end
        for (int i = 1; i < 256; i++) begin
            if (!s[i-1] && s[i]) begin
                if (first < 0) first = i;
                else if (per == 0) per = i - first;
            end
        end
        if (per != 0)
            for (int i = first; i < first + per; i++) hi += int'(s[i]);
    endtask

    task automatic shape(input string tag, input int lo, input int hi_f,
                         input bit off, input int exp_per, input int exp_hi);
        int p, h;
        set_cfg(lo, hi_f, 1'b0, off);
        repeat (70) @(posedge clk);
        measure(p, h);
        check({tag, " period"}, p, exp_per);
        check({tag, " high"}, h, exp_hi);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; restart = 1'b0; cfg_phase = '0;
        cfg_low = 4'd2; cfg_high = 4'd4; cfg_bypass = 1'b0; cfg_dcc_off = 1'b1;
        repeat (4) @(posedge clk);
        #(QTR);
        check("R1 in reset", int'(clk_out), 0);
        rst_n = 1'b1;
        @(posedge clk); #(QTR);
        check("R1 after reset", int'(clk_out), 0);
    endtask

    task automatic t_bypass();
        int p, h;
        set_cfg(3, 3, 1'b1, 1'b0);
        repeat (70) @(posedge clk);
        measure(p, h);
        check("R4 bypass period", p, 2);
        check("R4 bypass high", h, 1);
    endtask

    task automatic t_phase(input int ph, input int exp_edges);
        int k;
        set_cfg(2, 1, 1'b0, 1'b1);
        repeat (40) @(posedge clk);
        @(negedge clk);
        cfg_phase = PHASE_W'(ph);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        k = 0;
        // Edge E0 lies before the negedge above; count edges after it.
        for (int i = 1; i < 80; i++) begin
            @(posedge clk); #(QTR);
            if (clk_out) begin k = i; break; end
        end
        check($sformatf("R8 offset %0d first rise", ph), k, exp_edges);
    endtask

    task automatic t_no_runt();
        int p, h, cnt;
        bit prev;
        set_cfg(15, 15, 1'b0, 1'b1);
        repeat (70) @(posedge clk);
        prev = 1'b1;
        for (int i = 0; i < 200; i++) begin
            @(posedge clk); #(QTR);
            if (clk_out && !prev) break;
            prev = clk_out;
        end
        set_cfg(0, 0, 1'b0, 1'b1);
        cnt = 1;
        for (int i = 0; i < 40; i++) begin
            @(posedge clk); #(QTR);
            if (clk_out) cnt++;
            else break;
        end
        check("R9 high phase kept", cnt, 16);
        measure(p, h);
        check("R9 new period", p, 4);
        check("R9 new high", h, 2);
    endtask

    initial begin
        t_reset();
        shape("R2 M2 N4 off", 2, 4, 1'b1, 16, 10);
        shape("R3 min ratio", 0, 0, 1'b1, 4, 2);
        shape("R3 max ratio", 15, 15, 1'b1, 64, 32);
        t_bypass();
        shape("R5 even corrected", 0, 4, 1'b0, 12, 6);
        shape("R6 odd 5 corrected", 1, 2, 1'b0, 10, 5);
        shape("R6 odd 31 corrected", 15, 14, 1'b0, 62, 31);
        shape("R7 uneven uncorrected", 0, 4, 1'b1, 12, 10);
        t_phase(0, 4);
        t_phase(5, 9);
        t_phase(15, 19);
        t_no_runt();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule